// File: doc/BRIEF.md
# Serial Audio Transmitter

This block is the transmit side of a serial audio port that runs as clock master. It takes 32-bit parallel samples through a one-cycle ready pulse and a valid level. It divides its own clock, which serves as the oversampling clock, to make a bit clock. It drives a word-select line and a serial data line, most significant bit first. A frame is two system words. Word select marks the first one with a chosen level and the second one with the opposite level. Each system word carries one to four data words of the same length, and the bits left over are padding.

The data length, slot length, channel count and divider ratio are all taken from the configuration inputs. So are the bit-clock and word-select polarities, the padding level and side, the parallel justification and the one-bit data delay. The configuration is copied on every cycle the block is not running, so it holds for the whole of a run. A configuration whose data does not fit into its slot, or that uses an unused code, is refused.

The controller has three states. ST_IDLE holds the outputs at rest and copies the configuration. It moves to ST_RUN when enable is high and the configuration is good, and to ST_CFG_ERR when enable is high and the configuration is bad. ST_RUN goes back to ST_IDLE only at the last bit-clock edge of a frame, and only if enable is low by then. ST_CFG_ERR returns to ST_IDLE once enable is low.

Top module: `serial_audio_tx`

## Requirements
- R1: After reset the outputs are at rest: bck equals cfg_bck_inv, ws equals cfg_ws_inv, sd is 0, and in_ready, underflow and cfg_err are 0.
- R2: cfg_div codes 0 to 7 give N = 1, 2, 4 … 128, and codes 8 to 12 give N = 6, 12, 24, 48, 96. The bit clock toggles every N clock cycles, so one bit lasts 2N cycles. bck equals cfg_bck_inv in the first half of each bit and its inverse in the second half, and sd changes only at bit starts.
- R3: cfg_slen codes 0 to 7 give slot lengths of 8, 16, 24, 32, 48, 64, 128 and 256 bits. A frame is two slots. ws equals cfg_ws_inv during the first slot and its inverse during the second.
- R4: cfg_dlen codes 0 to 6 give 8, 16, 18, 20, 22, 24 and 32 bits. cfg_chans + 1 data words sit back to back in each slot, most significant bit first, and take samples in order of arrival.
- R5: With cfg_pad_lead = 0 the data words start at bit 0 of the slot. With cfg_pad_lead = 1 they end on the last bit of the slot. Every other bit of the slot equals cfg_pad_one.
- R6: With cfg_right_just = 0 the sample is taken from in_data[31] downward. With cfg_right_just = 1 it is taken from in_data[L-1] downward, where L is the data length.
- R7: With cfg_no_delay = 1 the bit stream lines up with ws. With cfg_no_delay = 0 sd lags it by one bit. The first delayed bit after a start equals cfg_pad_one.
- R8: in_ready is high for one cycle at the clock edge that begins the first bit of each data word. A sample is taken when in_valid is high in that cycle, so each frame takes 2 × (cfg_chans + 1) samples.
- R9: If in_valid is low at a take, the previous sample is sent again and underflow is set. underflow stays set until the next start.
- R10: If enable is high while the block is at rest and the data does not fit the slot (L × (cfg_chans + 1) greater than the slot length), or if cfg_dlen is 7, or if cfg_div is above 12, then cfg_err rises one edge later. While cfg_err is high no bit clock runs and no sample is taken, and cfg_err clears one edge after enable goes low.
- R11: A run starts at the first edge with enable high, and bit 0 begins there. Once enable is low, the current frame is completed and the outputs return to rest at its last edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run request |
| cfg_dlen | input | 3 | Data length code |
| cfg_slen | input | 3 | Slot length code |
| cfg_chans | input | 2 | Data words per slot minus one |
| cfg_div | input | 4 | Bit-clock divider code |
| cfg_bck_inv | input | 1 | Bit-clock level in the first half of a bit |
| cfg_ws_inv | input | 1 | Word-select level in the first slot |
| cfg_pad_one | input | 1 | Padding bit value |
| cfg_pad_lead | input | 1 | Padding before the data in the slot |
| cfg_right_just | input | 1 | Sample sits at the low end of in_data |
| cfg_no_delay | input | 1 | No one-bit data lag after ws |
| in_data | input | 32 | Parallel sample |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Take pulse |
| bck | output | 1 | Bit clock |
| ws | output | 1 | Word select |
| sd | output | 1 | Serial data |
| underflow | output | 1 | Sticky missed-sample flag |
| cfg_err | output | 1 | Configuration refused |

## Verification
When enable is first seen high at edge E0, bit g of the run holds from edge E0 + 2Ng to edge E0 + 2N(g+1). The bench samples sd, ws and bck at the first falling clock edge of each bit, then samples bck again N cycles later, when the second half of the bit has begun. The rest state is checked at the falling edge just after the final frame edge and once more N + 1 cycles later, so a frame that runs too long is caught. cfg_err is checked at the falling edge after the edge that saw enable. The number of samples taken and the underflow flag are checked once the run has ended.

// File: rtl/sat_pkg.sv
package sat_pkg;

    localparam int WORD_W = 32;
    localparam int DL_W   = $clog2(WORD_W) + 1;
    localparam int SL_W   = 9;
    localparam int DIV_W  = 8;

    typedef struct packed {
        logic [2:0] dlen;
        logic [2:0] slen;
        logic [1:0] chans;
        logic [3:0] div;
        logic       bck_inv;
        logic       ws_inv;
        logic       pad_one;
        logic       pad_lead;
        logic       right_just;
        logic       no_delay;
    } sat_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RUN     = 2'd1,
        ST_CFG_ERR = 2'd2
    } sat_state_e;

    function automatic logic [DL_W-1:0] dlen_bits(input logic [2:0] code);
        case (code)
            3'd0:    return DL_W'(8);
            3'd1:    return DL_W'(16);
            3'd2:    return DL_W'(18);
            3'd3:    return DL_W'(20);
            3'd4:    return DL_W'(22);
            3'd5:    return DL_W'(24);
            3'd6:    return DL_W'(32);
            default: return '0;
        endcase
    endfunction

    function automatic logic [SL_W-1:0] slen_bits(input logic [2:0] code);
        case (code)
            3'd0:    return SL_W'(8);
            3'd1:    return SL_W'(16);
            3'd2:    return SL_W'(24);
            3'd3:    return SL_W'(32);
            3'd4:    return SL_W'(48);
            3'd5:    return SL_W'(64);
            3'd6:    return SL_W'(128);
            default: return SL_W'(256);
        endcase
    endfunction

    // powers of two below code 8, six times a power of two from 8 to 12
    function automatic logic [DIV_W-1:0] div_ratio(input logic [3:0] code);
        if (code < 4'd8)
            return DIV_W'(1) << code[2:0];
        else if (code <= 4'd12)
            return DIV_W'(6) << code[2:0];
        else
            return '0;
    endfunction

    function automatic logic cfg_ok(input sat_cfg_t c);
        logic [SL_W-1:0] tot;
        tot = (SL_W'(c.chans) + SL_W'(1)) * SL_W'(dlen_bits(c.dlen));
        return (dlen_bits(c.dlen) != '0) && (div_ratio(c.div) != '0) &&
               (tot <= slen_bits(c.slen));
    endfunction

endpackage

// File: rtl/sat_bitclk.sv
module sat_bitclk #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] ratio,
    input  logic             bck_inv,
    output logic             bck,
    output logic             bit_end
);

    logic [DIV_W-1:0] cnt;
    logic             half;
    logic             at_lim;

    assign at_lim = (cnt == ratio - DIV_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            half <= 1'b0;
        end else if (!run) begin
            cnt  <= '0;
            half <= 1'b0;
        end else if (at_lim) begin
            cnt  <= '0;
            half <= ~half;
        end else begin
            cnt  <= cnt + DIV_W'(1);
        end
    end

    assign bit_end = run && half && at_lim;
    assign bck     = half ^ bck_inv;

endmodule

// File: rtl/sat_slot_seq.sv
module sat_slot_seq #(
    parameter int SL_W = 9,
    parameter int DL_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            active,
    input  logic            step,
    input  logic [DL_W-1:0] dlen,
    input  logic [SL_W-1:0] slen,
    input  logic [1:0]      chans,
    input  logic            pad_lead,
    output logic            in_data,
    output logic            load_nxt,
    output logic            frame_last,
    output logic            word
);

    logic [SL_W-1:0] q, nq, tot, s0;
    logic [DL_W-1:0] dbit;
    logic [1:0]      ch;
    logic            last_q, nword;

    assign tot    = (SL_W'(chans) + SL_W'(1)) * SL_W'(dlen);
    assign s0     = pad_lead ? (slen - tot) : '0;
    assign last_q = (q == slen - SL_W'(1));

    assign in_data = active && (q >= s0) &&
                     ({1'b0, q} < ({1'b0, s0} + {1'b0, tot}));

    assign nq    = (!active || last_q) ? '0 : q + SL_W'(1);
    assign nword = active && (last_q ? ~word : word);

    assign load_nxt = (nq == s0) ||
                      (in_data && (dbit == dlen - DL_W'(1)) && (ch != chans));

    assign frame_last = active && word && last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            word <= 1'b0;
            dbit <= '0;
            ch   <= '0;
        end else if (step) begin
            q    <= nq;
            word <= nword;
            if (load_nxt) begin
                dbit <= '0;
                ch   <= (nq == s0) ? 2'd0 : ch + 2'd1;
            end else if (in_data) begin
                dbit <= dbit + DL_W'(1);
            end
        end
    end

endmodule

// File: rtl/sat_shifter.sv
module sat_shifter #(
    parameter int WORD_W = 32,
    parameter int DL_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic              clr_flag,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic [DL_W-1:0]   dlen,
    input  logic              right_just,
    output logic              msb,
    output logic              underflow
);

    logic [WORD_W-1:0] sh, held, src, just;
    logic [DL_W-1:0]   shamt;

    assign src   = in_valid ? in_data : held;
    assign shamt = DL_W'(WORD_W) - dlen;
    assign just  = right_just ? (src << shamt) : src;
    assign msb   = sh[WORD_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh   <= '0;
            held <= '0;
        end else if (load) begin
            sh   <= just;
            held <= src;
        end else if (shift) begin
            sh   <= sh << 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            underflow <= 1'b0;
        else if (load && !in_valid)
            underflow <= 1'b1;
        else if (clr_flag)
            underflow <= 1'b0;
    end

endmodule

// File: rtl/serial_audio_tx.sv
module serial_audio_tx
    import sat_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic [2:0]  cfg_dlen,
    input  logic [2:0]  cfg_slen,
    input  logic [1:0]  cfg_chans,
    input  logic [3:0]  cfg_div,
    input  logic        cfg_bck_inv,
    input  logic        cfg_ws_inv,
    input  logic        cfg_pad_one,
    input  logic        cfg_pad_lead,
    input  logic        cfg_right_just,
    input  logic        cfg_no_delay,
    input  logic [31:0] in_data,
    input  logic        in_valid,
    output logic        in_ready,
    output logic        bck,
    output logic        ws,
    output logic        sd,
    output logic        underflow,
    output logic        cfg_err
);

    sat_state_e state_q, state_d;
    sat_cfg_t   cfg_in, cfg_q, cfg_eff;

    logic            run, start, stop, step, bit_end;
    logic            in_slot_data, load_nxt, frame_last, word;
    logic            msb, cur_bit, dly, bck_pol;
    logic [DL_W-1:0] dlen_w;

    assign cfg_in = '{dlen: cfg_dlen, slen: cfg_slen, chans: cfg_chans,
                      div: cfg_div, bck_inv: cfg_bck_inv, ws_inv: cfg_ws_inv,
                      pad_one: cfg_pad_one, pad_lead: cfg_pad_lead,
                      right_just: cfg_right_just, no_delay: cfg_no_delay};

    assign run     = (state_q == ST_RUN);
    assign cfg_eff = run ? cfg_q : cfg_in;
    assign dlen_w  = dlen_bits(cfg_eff.dlen);
    assign bck_pol = cfg_eff.bck_inv;

    assign start = (state_q == ST_IDLE) && enable && cfg_ok(cfg_in);
    assign stop  = bit_end && frame_last && !enable;
    assign step  = start || (bit_end && !stop);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (enable) state_d = cfg_ok(cfg_in) ? ST_RUN : ST_CFG_ERR;
            ST_RUN:     if (stop)   state_d = ST_IDLE;
            ST_CFG_ERR: if (!enable) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // configuration copy and one-bit delay stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            dly   <= 1'b0;
        end else begin
            if (!run)
                cfg_q <= cfg_in;
            if (!run)
                dly <= cfg_in.pad_one;
            else if (step)
                dly <= cur_bit;
        end
    end

    sat_bitclk #(.DIV_W(DIV_W)) i_bitclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .ratio   (div_ratio(cfg_eff.div)),
        .bck_inv (bck_pol),
        .bck     (bck),
        .bit_end (bit_end)
    );

    sat_slot_seq #(.SL_W(SL_W), .DL_W(DL_W)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (run),
        .step       (step),
        .dlen       (dlen_w),
        .slen       (slen_bits(cfg_eff.slen)),
        .chans      (cfg_eff.chans),
        .pad_lead   (cfg_eff.pad_lead),
        .in_data    (in_slot_data),
        .load_nxt   (load_nxt),
        .frame_last (frame_last),
        .word       (word)
    );

    sat_shifter #(.WORD_W(WORD_W), .DL_W(DL_W)) i_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (step && load_nxt),
        .shift      (step && in_slot_data),
        .clr_flag   (start),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .dlen       (dlen_w),
        .right_just (cfg_eff.right_just),
        .msb        (msb),
        .underflow  (underflow)
    );

    assign cur_bit = in_slot_data ? msb : cfg_eff.pad_one;

    // outputs
    always_comb begin
        cfg_err  = (state_q == ST_CFG_ERR);
        in_ready = step && load_nxt;
        sd       = run ? (cfg_eff.no_delay ? cur_bit : dly) : 1'b0;
        ws       = run ? (word ^ cfg_eff.ws_inv) : cfg_eff.ws_inv;
    end

endmodule

// File: rtl/serial_audio_tx_chk.sv
module serial_audio_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic run,
    input logic start,
    input logic bit_end,
    input logic in_ready,
    input logic in_valid,
    input logic underflow,
    input logic cfg_err,
    input logic bck,
    input logic ws,
    input logic bck_pol
);

    // R1
    rest_bck_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (bck == bck_pol));

    // R8
    ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> !in_ready);

    // R10
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!in_ready && !run));

    // R9
    uflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underflow) |-> $past(in_ready && !in_valid));

    // R9
    uflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !start) |=> underflow);

    // R3
    ws_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !bit_end) |=> $stable(ws));

endmodule

bind serial_audio_tx serial_audio_tx_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .start     (start),
    .bit_end   (bit_end),
    .in_ready  (in_ready),
    .in_valid  (in_valid),
    .underflow (underflow),
    .cfg_err   (cfg_err),
    .bck       (bck),
    .ws        (ws),
    .bck_pol   (bck_pol)
);

// File: tb/test_serial_audio_tx.sv
module test_serial_audio_tx;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [2:0]  c_dlen = '0, c_slen = '0;
    logic [1:0]  c_chans = '0;
    logic [3:0]  c_div = '0;
    logic        c_bck_inv = 0, c_ws_inv = 0, c_pad_one = 0;
    logic        c_pad_lead = 0, c_right_just = 0, c_no_delay = 0;
    logic [31:0] in_data;
    logic        in_valid, in_ready, bck, ws, sd, underflow, cfg_err;

    int idx = 0;
    int lim = 0;
    int checks = 0;
    int fails = 0;
    int g_dl, g_sl, g_ch, g_r;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] smp(input int i);
        return ((32'(i) + 32'd1) * 32'h9E3779B9) ^ 32'h0F1E2D3C;
    endfunction

    assign in_data  = smp(idx);
    assign in_valid = (idx < lim);

    serial_audio_tx i_serial_audio_tx (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .cfg_dlen(c_dlen), .cfg_slen(c_slen), .cfg_chans(c_chans), .cfg_div(c_div),
        .cfg_bck_inv(c_bck_inv), .cfg_ws_inv(c_ws_inv), .cfg_pad_one(c_pad_one),
        .cfg_pad_lead(c_pad_lead), .cfg_right_just(c_right_just), .cfg_no_delay(c_no_delay),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .bck(bck), .ws(ws), .sd(sd), .underflow(underflow), .cfg_err(cfg_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int dl_of(input int c);
        case (c) 0: return 8; 1: return 16; 2: return 18; 3: return 20;
                 4: return 22; 5: return 24; default: return 32; endcase
    endfunction

    function automatic int sl_of(input int c);
        case (c) 0: return 8; 1: return 16; 2: return 24; 3: return 32;
                 4: return 48; 5: return 64; 6: return 128; default: return 256; endcase
    endfunction

    function automatic int r_of(input int c);
        return (c < 8) ? (1 << c) : (6 << (c - 8));
    endfunction

    // expected bit g of the undelayed stream (R4, R5, R6, R9)
    function automatic logic logical_bit(input int g);
        int fl, f, p, wd, q, tot, s0, c, k, i;
        logic [31:0] s;
        fl  = 2 * g_sl;
        f   = g / fl;
        p   = g % fl;
        wd  = p / g_sl;
        q   = p % g_sl;
        tot = g_ch * g_dl;
        s0  = c_pad_lead ? (g_sl - tot) : 0;
        if (q < s0 || q >= s0 + tot) return c_pad_one;
        c = (q - s0) / g_dl;
        k = (q - s0) % g_dl;
        i = f * 2 * g_ch + wd * g_ch + c;
        if (i >= lim) i = lim - 1;
        s = smp(i);
        return c_right_just ? s[g_dl - 1 - k] : s[31 - k];
    endfunction

    // sample feeder: takes a sample on each in_ready pulse
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (in_ready && in_valid) begin
                @(posedge clk);
                #1;
                idx++;
            end
        end
    end

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 bck", bck, 0);
        chk("R1 ws", ws, 0);
        chk("R1 sd", sd, 0);
        chk("R1 in_ready", in_ready, 0);
        chk("R1 cfg_err", cfg_err, 0);
        chk("R1 underflow", underflow, 0);
    endtask

    task automatic run_scen(input string name, input int dl_c, input int sl_c,
                            input int ch_c, input int div_c,
                            input bit bi, input bit wi, input bit po, input bit pl,
                            input bit rj, input bit nd, input int nframes, input int limit);
        int fl, need;
        logic e;
        c_dlen = 3'(dl_c); c_slen = 3'(sl_c); c_chans = 2'(ch_c); c_div = 4'(div_c);
        c_bck_inv = bi; c_ws_inv = wi; c_pad_one = po; c_pad_lead = pl;
        c_right_just = rj; c_no_delay = nd;
        g_dl = dl_of(dl_c); g_sl = sl_of(sl_c); g_ch = ch_c + 1; g_r = r_of(div_c);
        lim = limit; idx = 0;
        fl = 2 * g_sl;
        need = 2 * g_ch * nframes;
        enable = 1'b1;
        @(negedge clk);
        for (int g = 0; g < nframes * fl; g++) begin
            if (g == (nframes - 1) * fl) enable = 1'b0;  // R11: frame still completes
            e = nd ? logical_bit(g) : ((g == 0) ? po : logical_bit(g - 1));
            chk({name, " R4 R5 R6 R7 R11 sd"}, sd, e);
            chk({name, " R3 ws"}, ws, 32'((((g % fl) >= g_sl) ? 1 : 0) ^ int'(wi)));
            chk({name, " R2 bck first half"}, bck, bi);
            repeat (g_r) @(negedge clk);
            chk({name, " R2 bck second half"}, bck, !bi);
            repeat (g_r) @(negedge clk);
        end
        chk({name, " R11 rest bck"}, bck, bi);
        chk({name, " R11 rest sd"}, sd, 0);
        chk({name, " R11 rest ws"}, ws, wi);
        chk({name, " R11 rest in_ready"}, in_ready, 0);
        repeat (g_r + 1) @(negedge clk);
        chk({name, " R11 still at rest"}, bck, bi);
        chk({name, " R8 samples taken"}, idx, (need < limit) ? need : limit);
        chk({name, " R9 underflow flag"}, underflow, (need > limit) ? 1 : 0);
    endtask

    task automatic t_cfg_err;
        idx = 0; lim = 1000;
        c_bck_inv = 1'b1; c_div = 4'd0; c_chans = 2'd1;
        c_dlen = 3'd5; c_slen = 3'd3;              // 2 x 24 in 32
        enable = 1'b1;
        @(negedge clk);
        chk("R10 cfg_err on overfill", cfg_err, 1);
        repeat (4) begin
            @(negedge clk);
            chk("R10 bck held", bck, 1);
            chk("R10 no take", in_ready, 0);
        end
        chk("R10 no sample taken", idx, 0);
        enable = 1'b0;
        @(negedge clk);
        chk("R10 cfg_err clears", cfg_err, 0);
        c_chans = 2'd0; c_dlen = 3'd7;             // unused length code
        enable = 1'b1;
        @(negedge clk);
        chk("R10 cfg_err on length code 7", cfg_err, 1);
        enable = 1'b0;
        @(negedge clk);
        c_dlen = 3'd0; c_div = 4'd13;              // unused divider code
        enable = 1'b1;
        @(negedge clk);
        chk("R10 cfg_err on divider code 13", cfg_err, 1);
        enable = 1'b0;
        @(negedge clk);
        chk("R10 cfg_err clears again", cfg_err, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        run_scen("i2s16",   1, 1, 0, 1,  0, 0, 0, 0, 0, 0, 2, 1000);
        run_scen("padlead", 0, 3, 1, 8,  0, 1, 1, 1, 1, 1, 2, 1000);
        run_scen("odd18",   2, 2, 0, 0,  1, 0, 0, 0, 0, 0, 2, 1000);
        run_scen("full32",  6, 3, 0, 0,  0, 0, 1, 0, 1, 0, 2, 1000);
        run_scen("quad8",   0, 3, 3, 2,  0, 1, 0, 0, 0, 0, 1, 1000);
        run_scen("under",   1, 1, 0, 1,  0, 0, 0, 0, 0, 0, 2, 3);
        run_scen("slow96",  0, 0, 0, 12, 1, 0, 1, 1, 0, 1, 1, 1000);
        t_cfg_err();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule